// File: doc/BRIEF.md
# Two-Level Instruction Decoder

This block turns one 32-bit instruction word into a set of control signals for a simple load/store pipeline. Decoding runs in two levels. The top two bits pick a class and the next four bits pick a subclass. Some groups then read a further opcode field, and where that field sits depends on the group. The outputs are:

- an operation number;
- the three register index fields;
- a 32-bit immediate, extended according to the operation;
- a flag that selects the immediate as the second operand;
- a flag for a write to the destination register;
- memory read and write strobes, with access size and load extension;
- an illegal-instruction flag.

One parameter places an output register, with a clock enable, behind the decoder. The default configuration has this register, so results appear one clock after capture. Any encoding the decoder does not know raises the illegal flag and yields a quiet no-operation. The rest of the pipeline can then trap without having to inspect the other outputs.

Top module: `insn_decoder`

## Requirements
- R1: The outputs rd_idx, ra_idx and rb_idx always carry bits 25-21, 20-16 and 15-11 of the word, whatever the word decodes to. The class is bits 31-30 and the subclass is bits 29-26.
- R2: In class 0, subclasses 0 to 4 give op 1 (jump), 2 (jump and link), 3 (branch and link), 4 (branch if flag clear) and 5 (branch if flag set). The immediate is bits 25-0 sign-extended. use_imm and wr_rd are 0.
- R3: Class 0, subclass 5 decodes on bits 25-24 (A) and bits 23-21 (B):
  - A=0, B=0 gives op 6 (jump register).
  - A=0, B=1 gives op 7 (jump register and link).
  - A=0, B=2 gives op 8 (return from exception).
  - A=1, B=0 gives op 0 (no-op) and is legal.
  - A=2 gives op 9 (system call) for any B.
  - A=3 gives op 10 (break) for any B.
  - Ops 9 and 10 zero-extend bits 15-0 into the immediate.
  - Every other combination is illegal.
- R4: Class 0, subclass 6 gives op 11 (move high). Its immediate is bits 15-0 shifted left by 16, with use_imm=1 and wr_rd=1. Class 0, subclass 7 gives op 12 (read special register) with wr_rd=1. Class 1, subclass 0 gives op 13 (write special register).
- R5: Class 2, subclasses 0 to 4 are loads, with op 14 to 18 in subclass order:
  - subclass 0: word, mem_size 2;
  - subclass 1: byte zero-extended, mem_size 0;
  - subclass 2: byte sign-extended, mem_size 0;
  - subclass 3: halfword zero-extended, mem_size 1;
  - subclass 4: halfword sign-extended, mem_size 1.
  mem_sext is 1 only for subclasses 2 and 4. mem_rd, use_imm and wr_rd are 1. The immediate is bits 15-0 sign-extended.
- R6: Class 3, subclasses 5, 6 and 7 are stores, with op 19, 20 and 21 and mem_size 2, 0 and 1. mem_wr and use_imm are 1 and wr_rd is 0. The offset is bits 25-21 as the upper five bits joined to bits 10-0, sign-extended from 16 bits.
- R7: Class 3, subclass 8 selects a register-register operation with bits 3-0:
  - 0 gives op 22 (add), 2 gives 23 (sub), 3 gives 24 (and), 4 gives 25 (or);
  - 5 gives 26 (xor), 6 gives 27 (mul);
  - 9 gives 32 (signed divide), 10 gives 33 (unsigned divide).
  wr_rd=1 and use_imm=0. Other values of bits 3-0, except 8 (see R8), are illegal.
- R8: Shifts take their type from bits 7-5: 0 gives op 28 (left), 1 gives 29 (logical right), 2 gives 30 (arithmetic right), 4 gives 31 (rotate right). Other types are illegal.
  - The register form is class 3, subclass 8 with bits 3-0 equal to 8, and has use_imm=0.
  - The immediate form is class 2, subclass 13. It has use_imm=1 and an immediate of bits 4-0 zero-extended.
  - Both forms have wr_rd=1.
- R9: The immediate ALU forms are in class 2: subclass 5 gives op 22, 7 gives 23, 8 gives 24, 9 gives 25, 10 gives 26 and 11 gives 27. Subclasses 5 and 7 sign-extend bits 15-0. Subclasses 8 to 11 zero-extend them. use_imm and wr_rd are 1.
- R10: Compares take a condition from bits 25-21, and the op is 34 plus the condition:
  - 0 equal, 1 not equal;
  - 2 to 5: unsigned greater, greater-or-equal, less, less-or-equal;
  - 6 to 9: signed greater, greater-or-equal, less, less-or-equal.
  The register form is class 3, subclass 9. The immediate form is class 2, subclass 14 with use_imm=1; it zero-extends bits 15-0 for conditions 2 to 5 and sign-extends them otherwise. wr_rd is 0. A condition above 9 is illegal.
- R11: Every class, subclass or sub-opcode combination not listed above sets illegal=1 with op 0, an immediate of 0, and use_imm, wr_rd, mem_rd, mem_wr, mem_size and mem_sext all 0.
- R12: With the output register in place (the default), reset drives op and every flag to 0. The outputs take the decode of the word present at a rising clock edge only when en is 1 at that edge. With en at 0 they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the output register |
| insn | input | 32 | Instruction word |
| op | output | 6 | Operation number |
| rd_idx | output | 5 | Destination register field |
| ra_idx | output | 5 | First source register field |
| rb_idx | output | 5 | Second source register field |
| imm | output | 32 | Extended immediate |
| use_imm | output | 1 | Second operand comes from imm |
| wr_rd | output | 1 | Destination register is written |
| mem_rd | output | 1 | Memory load |
| mem_wr | output | 1 | Memory store |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_sext | output | 1 | Load result is sign-extended |
| illegal | output | 1 | Unknown encoding |

## Verification
The bench aims at the split store offset with its top bit set. A decoder that read bits 15-0 instead would return a positive offset built from the rB field. It also separates sign and zero extension in each immediate group. Swapping the rules for the unsigned-compare or logical groups flips bit 31 of a 0x8000 immediate.

The no-op slot in the subclass-5 group and the shift-type gaps (type 3) are checked as well. Catching one encoding too many or too few there shows up as a wrong illegal flag. Holding the output while en is low is also exercised, because a register that ignored its enable would show the newer word.

// File: rtl/dec_pkg.sv
package dec_pkg;

  localparam int INSN_W  = 32;
  localparam int REG_W   = 5;
  localparam int OP_W    = 6;
  localparam int CLS_LSB = 30;
  localparam int SUB_LSB = 26;
  localparam int RD_LSB  = 21;
  localparam int RA_LSB  = 16;
  localparam int RB_LSB  = 11;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 6'd0,  OP_J     = 6'd1,  OP_JAL   = 6'd2,  OP_BAL   = 6'd3,
    OP_BNF   = 6'd4,  OP_BF    = 6'd5,  OP_JR    = 6'd6,  OP_JALR  = 6'd7,
    OP_RFE   = 6'd8,  OP_SYS   = 6'd9,  OP_BRK   = 6'd10, OP_MOVHI = 6'd11,
    OP_MFSR  = 6'd12, OP_MTSR  = 6'd13, OP_LW    = 6'd14, OP_LBZ   = 6'd15,
    OP_LBS   = 6'd16, OP_LHZ   = 6'd17, OP_LHS   = 6'd18, OP_SW    = 6'd19,
    OP_SB    = 6'd20, OP_SH    = 6'd21, OP_ADD   = 6'd22, OP_SUB   = 6'd23,
    OP_AND   = 6'd24, OP_OR    = 6'd25, OP_XOR   = 6'd26, OP_MUL   = 6'd27,
    OP_SLL   = 6'd28, OP_SRL   = 6'd29, OP_SRA   = 6'd30, OP_ROR   = 6'd31,
    OP_DIV   = 6'd32, OP_DIVU  = 6'd33, OP_CEQ   = 6'd34, OP_CNE   = 6'd35,
    OP_CGTU  = 6'd36, OP_CGEU  = 6'd37, OP_CLTU  = 6'd38, OP_CLEU  = 6'd39,
    OP_CGTS  = 6'd40, OP_CGES  = 6'd41, OP_CLTS  = 6'd42, OP_CLES  = 6'd43
  } op_e;

  typedef enum logic [2:0] {
    IMM_ZERO, IMM_S26, IMM_S16, IMM_Z16, IMM_HI, IMM_ST, IMM_Z5
  } imm_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2
  } mem_sz_e;

  typedef struct packed {
    op_e               op;
    logic [REG_W-1:0]  rd;
    logic [REG_W-1:0]  ra;
    logic [REG_W-1:0]  rb;
    logic [INSN_W-1:0] imm;
    logic              use_imm;
    logic              wr_rd;
    logic              mem_rd;
    logic              mem_wr;
    logic [1:0]        mem_size;
    logic              mem_sext;
    logic              illegal;
  } dec_t;

endpackage

// File: rtl/dec_imm_gen.sv
module dec_imm_gen
  import dec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  imm_kind_e         kind,
  output logic [INSN_W-1:0] imm
);

  localparam int LO_W  = 16;
  localparam int JD_W  = 26;
  localparam int SA_W  = 5;
  localparam int STL_W = LO_W - REG_W;

  logic [LO_W-1:0] lo16;
  logic [LO_W-1:0] st16;

  assign lo16 = insn[LO_W-1:0];
  // store offset: rD field on top, low eleven bits below
  assign st16 = {insn[RD_LSB +: REG_W], insn[STL_W-1:0]};

  always_comb begin
    case (kind)
      IMM_S26: imm = {{(INSN_W-JD_W){insn[JD_W-1]}}, insn[JD_W-1:0]};
      IMM_S16: imm = {{(INSN_W-LO_W){lo16[LO_W-1]}}, lo16};
      IMM_Z16: imm = {{(INSN_W-LO_W){1'b0}}, lo16};
      IMM_HI:  imm = {lo16, {(INSN_W-LO_W){1'b0}}};
      IMM_ST:  imm = {{(INSN_W-LO_W){st16[LO_W-1]}}, st16};
      IMM_Z5:  imm = {{(INSN_W-SA_W){1'b0}}, insn[SA_W-1:0]};
      default: imm = '0;
    endcase
  end

endmodule

// File: rtl/dec_opcode.sv
module dec_opcode
  import dec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output op_e               op,
  output imm_kind_e         kind,
  output logic              use_imm,
  output logic              wr_rd,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [1:0]        mem_size,
  output logic              mem_sext,
  output logic              illegal
);

  logic [1:0] cls;
  logic [3:0] sub;
  logic [1:0] grp_hi;
  logic [2:0] grp_lo;
  logic [2:0] sh_type;
  logic [3:0] funct;
  logic [4:0] cond;

  assign cls     = insn[CLS_LSB +: 2];
  assign sub     = insn[SUB_LSB +: 4];
  assign grp_hi  = insn[RD_LSB+3 +: 2];
  assign grp_lo  = insn[RD_LSB +: 3];
  assign sh_type = insn[7:5];
  assign funct   = insn[3:0];
  assign cond    = insn[RD_LSB +: REG_W];

  // shift type lookup shared by register and immediate forms
  op_e  sh_op;
  logic sh_ok;
  always_comb begin
    sh_ok = 1'b1;
    case (sh_type)
      3'd0:    sh_op = OP_SLL;
      3'd1:    sh_op = OP_SRL;
      3'd2:    sh_op = OP_SRA;
      3'd4:    sh_op = OP_ROR;
      default: begin sh_op = OP_NOP; sh_ok = 1'b0; end
    endcase
  end

  // compare condition lookup shared by both compare forms
  op_e  cmp_op;
  logic cmp_ok;
  logic cmp_uns;
  always_comb begin
    cmp_ok  = (cond <= 5'd9);
    cmp_uns = (cond >= 5'd2) && (cond <= 5'd5);
    cmp_op  = cmp_ok ? op_e'(6'(OP_CEQ) + 6'(cond)) : OP_NOP;
  end

  logic bad;
  always_comb begin
    op = OP_NOP; kind = IMM_ZERO; use_imm = 1'b0; wr_rd = 1'b0;
    mem_rd = 1'b0; mem_wr = 1'b0; mem_size = 2'd0; mem_sext = 1'b0;
    bad = 1'b0;
    case (cls)
      2'd0: begin
        case (sub)
          4'd0: begin op = OP_J;   kind = IMM_S26; end
          4'd1: begin op = OP_JAL; kind = IMM_S26; end
          4'd2: begin op = OP_BAL; kind = IMM_S26; end
          4'd3: begin op = OP_BNF; kind = IMM_S26; end
          4'd4: begin op = OP_BF;  kind = IMM_S26; end
          4'd5: begin
            case (grp_hi)
              2'd0: begin
                case (grp_lo)
                  3'd0:    op = OP_JR;
                  3'd1:    op = OP_JALR;
                  3'd2:    op = OP_RFE;
                  default: bad = 1'b1;
                endcase
              end
              2'd1:    bad = (grp_lo != 3'd0);
              2'd2:    begin op = OP_SYS; kind = IMM_Z16; end
              default: begin op = OP_BRK; kind = IMM_Z16; end
            endcase
          end
          4'd6: begin op = OP_MOVHI; kind = IMM_HI; use_imm = 1'b1; wr_rd = 1'b1; end
          4'd7: begin op = OP_MFSR; wr_rd = 1'b1; end
          default: bad = 1'b1;
        endcase
      end
      2'd1: begin
        if (sub == 4'd0) op = OP_MTSR;
        else             bad = 1'b1;
      end
      2'd2: begin
        case (sub)
          4'd0, 4'd1, 4'd2, 4'd3, 4'd4: begin
            op = op_e'(6'(OP_LW) + 6'(sub));
            kind = IMM_S16; use_imm = 1'b1; wr_rd = 1'b1; mem_rd = 1'b1;
            mem_size = (sub == 4'd0) ? SZ_WORD : (sub <= 4'd2) ? SZ_BYTE : SZ_HALF;
            mem_sext = (sub == 4'd2) || (sub == 4'd4);
          end
          4'd5:  begin op = OP_ADD; kind = IMM_S16; use_imm = 1'b1; wr_rd = 1'b1; end
          4'd7:  begin op = OP_SUB; kind = IMM_S16; use_imm = 1'b1; wr_rd = 1'b1; end
          4'd8, 4'd9, 4'd10, 4'd11: begin
            op = op_e'(6'(OP_AND) + 6'(sub - 4'd8));
            kind = IMM_Z16; use_imm = 1'b1; wr_rd = 1'b1;
          end
          4'd13: begin
            if (sh_ok) begin op = sh_op; kind = IMM_Z5; use_imm = 1'b1; wr_rd = 1'b1; end
            else       bad = 1'b1;
          end
          4'd14: begin
            if (cmp_ok) begin
              op = cmp_op; use_imm = 1'b1;
              kind = cmp_uns ? IMM_Z16 : IMM_S16;
            end else bad = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      default: begin
        case (sub)
          4'd5: begin op = OP_SW; kind = IMM_ST; use_imm = 1'b1; mem_wr = 1'b1; mem_size = SZ_WORD; end
          4'd6: begin op = OP_SB; kind = IMM_ST; use_imm = 1'b1; mem_wr = 1'b1; mem_size = SZ_BYTE; end
          4'd7: begin op = OP_SH; kind = IMM_ST; use_imm = 1'b1; mem_wr = 1'b1; mem_size = SZ_HALF; end
          4'd8: begin
            wr_rd = 1'b1;
            case (funct)
              4'd0:    op = OP_ADD;
              4'd2:    op = OP_SUB;
              4'd3:    op = OP_AND;
              4'd4:    op = OP_OR;
              4'd5:    op = OP_XOR;
              4'd6:    op = OP_MUL;
              4'd8:    begin op = sh_op; bad = !sh_ok; end
              4'd9:    op = OP_DIV;
              4'd10:   op = OP_DIVU;
              default: bad = 1'b1;
            endcase
            if (bad) wr_rd = 1'b0;
          end
          4'd9: begin
            if (cmp_ok) op = cmp_op;
            else        bad = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
    endcase
    illegal = bad;
  end

endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage
  import dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  dec_t d,
  output dec_t q
);

  generate
    if (REG_OUT) begin : g_reg
      dec_t q_r;
      dec_t q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (en) q_nxt = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q = q_r;

      // R12
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q_r));
      // R12
      capture_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q_r == $past(d)));
    end else begin : g_comb
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INSN_W-1:0] insn,
  output logic [OP_W-1:0]   op,
  output logic [REG_W-1:0]  rd_idx,
  output logic [REG_W-1:0]  ra_idx,
  output logic [REG_W-1:0]  rb_idx,
  output logic [INSN_W-1:0] imm,
  output logic              use_imm,
  output logic              wr_rd,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [1:0]        mem_size,
  output logic              mem_sext,
  output logic              illegal
);

  op_e               c_op;
  imm_kind_e         c_kind;
  logic [INSN_W-1:0] c_imm;
  logic              c_use_imm, c_wr_rd, c_mem_rd, c_mem_wr, c_mem_sext, c_illegal;
  logic [1:0]        c_mem_size;
  dec_t              dec_c;
  dec_t              dec_q;

  dec_opcode u_opcode (
    .insn     (insn),
    .op       (c_op),
    .kind     (c_kind),
    .use_imm  (c_use_imm),
    .wr_rd    (c_wr_rd),
    .mem_rd   (c_mem_rd),
    .mem_wr   (c_mem_wr),
    .mem_size (c_mem_size),
    .mem_sext (c_mem_sext),
    .illegal  (c_illegal)
  );

  dec_imm_gen u_imm (
    .insn (insn),
    .kind (c_kind),
    .imm  (c_imm)
  );

  always_comb begin
    dec_c.op       = c_op;
    dec_c.rd       = insn[RD_LSB +: REG_W];
    dec_c.ra       = insn[RA_LSB +: REG_W];
    dec_c.rb       = insn[RB_LSB +: REG_W];
    dec_c.imm      = c_imm;
    dec_c.use_imm  = c_use_imm;
    dec_c.wr_rd    = c_wr_rd;
    dec_c.mem_rd   = c_mem_rd;
    dec_c.mem_wr   = c_mem_wr;
    dec_c.mem_size = c_mem_size;
    dec_c.mem_sext = c_mem_sext;
    dec_c.illegal  = c_illegal;
  end

  // R6
  store_offset_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mem_wr && insn[RD_LSB+REG_W-1]) |-> c_imm[INSN_W-1]);
  // R11
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_illegal |-> (c_imm == '0 && !c_mem_rd && !c_mem_wr && !c_wr_rd && !c_use_imm));
  // R5
  load_controls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_mem_rd |-> (c_use_imm && c_wr_rd && !c_mem_wr));

  dec_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .d     (dec_c),
    .q     (dec_q)
  );

  assign op       = dec_q.op;
  assign rd_idx   = dec_q.rd;
  assign ra_idx   = dec_q.ra;
  assign rb_idx   = dec_q.rb;
  assign imm      = dec_q.imm;
  assign use_imm  = dec_q.use_imm;
  assign wr_rd    = dec_q.wr_rd;
  assign mem_rd   = dec_q.mem_rd;
  assign mem_wr   = dec_q.mem_wr;
  assign mem_size = dec_q.mem_size;
  assign mem_sext = dec_q.mem_sext;
  assign illegal  = dec_q.illegal;

endmodule

// File: tb/insn_decoder_tb_top.sv
`timescale 1ns/1ps
module insn_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] insn = 32'h0;
  logic [5:0]  op;
  logic [4:0]  rd_idx, ra_idx, rb_idx;
  logic [31:0] imm;
  logic        use_imm, wr_rd, mem_rd, mem_wr, mem_sext, illegal;
  logic [1:0]  mem_size;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  insn_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .insn(insn), .op(op),
    .rd_idx(rd_idx), .ra_idx(ra_idx), .rb_idx(rb_idx), .imm(imm),
    .use_imm(use_imm), .wr_rd(wr_rd), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_size(mem_size), .mem_sext(mem_sext), .illegal(illegal)
  );

  function automatic logic [31:0] mk(int c, int s, logic [25:0] rest);
    logic [1:0] cc; logic [3:0] ss;
    cc = c[1:0]; ss = s[3:0];
    return {cc, ss, rest};
  endfunction

  function automatic logic [31:0] sx16(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic expect_dec(string tag, int e_op, logic [31:0] e_imm, bit e_ui, bit e_wr,
                            bit e_mr, bit e_mw, int e_sz, bit e_sx, bit e_il);
    chk({tag, " op"},       {26'b0, op},       32'(e_op));
    chk({tag, " imm"},      imm,               e_imm);
    chk({tag, " use_imm"},  {31'b0, use_imm},  {31'b0, e_ui});
    chk({tag, " wr_rd"},    {31'b0, wr_rd},    {31'b0, e_wr});
    chk({tag, " mem_rd"},   {31'b0, mem_rd},   {31'b0, e_mr});
    chk({tag, " mem_wr"},   {31'b0, mem_wr},   {31'b0, e_mw});
    chk({tag, " mem_size"}, {30'b0, mem_size}, 32'(e_sz));
    chk({tag, " mem_sext"}, {31'b0, mem_sext}, {31'b0, e_sx});
    chk({tag, " illegal"},  {31'b0, illegal},  {31'b0, e_il});
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    insn = w; en = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_bad(string tag, logic [31:0] w);
    apply(w);
    expect_dec(tag, 0, 32'h0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset;
    chk("R12 reset op", {26'b0, op}, 32'h0);
    chk("R12 reset illegal", {31'b0, illegal}, 32'h0);
    chk("R12 reset wr_rd", {31'b0, wr_rd}, 32'h0);
  endtask

  task automatic t_fields;
    logic [25:0] r;
    r = {5'd19, 5'd7, 16'hA5C3};
    apply(mk(2, 5, r));
    chk("R1 rd", {27'b0, rd_idx}, 32'd19);
    chk("R1 ra", {27'b0, ra_idx}, 32'd7);
    chk("R1 rb", {27'b0, rb_idx}, {27'b0, 5'b10100});
    expect_dec("R9 addi", 22, sx16(16'hA5C3), 1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_jumps;
    for (int s = 0; s < 5; s++) begin
      apply(mk(0, s, 26'h2000001));
      expect_dec("R2 neg", s + 1, 32'hFE000001, 0, 0, 0, 0, 0, 0, 0);
    end
    apply(mk(0, 4, 26'h0123456));
    expect_dec("R2 pos", 5, 32'h00123456, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sub5;
    apply(mk(0, 5, {2'd0, 3'd0, 21'h0}));
    expect_dec("R3 jr", 6, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(mk(0, 5, {2'd0, 3'd1, 21'h0}));
    expect_dec("R3 jalr", 7, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(mk(0, 5, {2'd0, 3'd2, 21'h0}));
    expect_dec("R3 rfe", 8, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(mk(0, 5, {2'd1, 3'd0, 21'h0}));
    expect_dec("R3 nop", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_bad("R3 bad 1,3", mk(0, 5, {2'd1, 3'd3, 21'h0}));
    expect_bad("R3 bad 0,5", mk(0, 5, {2'd0, 3'd5, 21'h0}));
    apply(mk(0, 5, {2'd2, 3'd6, 5'd0, 16'h8001}));
    expect_dec("R3 sys", 9, 32'h00008001, 0, 0, 0, 0, 0, 0, 0);
    apply(mk(0, 5, {2'd3, 3'd0, 5'd0, 16'hFFFF}));
    expect_dec("R3 brk", 10, 32'h0000FFFF, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_special;
    apply(mk(0, 6, {10'h0, 16'h8765}));
    expect_dec("R4 movhi", 11, 32'h87650000, 1, 1, 0, 0, 0, 0, 0);
    apply(mk(0, 7, {5'd3, 5'd4, 16'h0}));
    expect_dec("R4 mfsr", 12, 0, 0, 1, 0, 0, 0, 0, 0);
    apply(mk(1, 0, {5'd3, 5'd4, 16'h0}));
    expect_dec("R4 mtsr", 13, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_loads;
    int sz[5] = '{2, 0, 0, 1, 1};
    bit sx[5] = '{0, 0, 1, 0, 1};
    for (int s = 0; s < 5; s++) begin
      apply(mk(2, s, {10'h0, 16'hFFF0}));
      expect_dec("R5 load", 14 + s, 32'hFFFFFFF0, 1, 1, 1, 0, sz[s], sx[s], 0);
    end
  endtask

  task automatic t_stores;
    int sz[3] = '{2, 0, 1};
    for (int s = 0; s < 3; s++) begin
      apply(mk(3, 5 + s, {5'b10000, 5'd2, 5'd9, 11'h005}));
      expect_dec("R6 store neg", 19 + s, 32'hFFFF8005, 1, 0, 0, 1, sz[s], 0, 0);
    end
    apply(mk(3, 5, {5'b00011, 5'd2, 5'b11111, 11'h7FF}));
    expect_dec("R6 store pos", 19, 32'h00001FFF, 1, 0, 0, 1, 2, 0, 0);
  endtask

  task automatic t_alu_reg;
    int fn[8] = '{0, 2, 3, 4, 5, 6, 9, 10};
    int eo[8] = '{22, 23, 24, 25, 26, 27, 32, 33};
    int badf[4] = '{1, 7, 11, 15};
    for (int i = 0; i < 8; i++) begin
      apply(mk(3, 8, {15'h0, 7'h0, 4'(fn[i])}));
      expect_dec("R7 alu reg", eo[i], 0, 0, 1, 0, 0, 0, 0, 0);
    end
    for (int i = 0; i < 4; i++)
      expect_bad("R7 bad funct", mk(3, 8, {15'h0, 7'h0, 4'(badf[i])}));
  endtask

  task automatic t_shifts;
    int ty[4] = '{0, 1, 2, 4};
    for (int i = 0; i < 4; i++) begin
      apply(mk(3, 8, {15'h0, 3'b0, 3'(ty[i]), 1'b0, 4'd8}));
      expect_dec("R8 shift reg", 28 + i, 0, 0, 1, 0, 0, 0, 0, 0);
      apply(mk(2, 13, {10'h0, 8'h0, 3'(ty[i]), 5'h1F}));
      expect_dec("R8 shift imm", 28 + i, 32'd31, 1, 1, 0, 0, 0, 0, 0);
    end
    expect_bad("R8 bad reg type", mk(3, 8, {15'h0, 3'b0, 3'd3, 1'b0, 4'd8}));
    expect_bad("R8 bad imm type", mk(2, 13, {10'h0, 8'h0, 3'd7, 5'h01}));
  endtask

  task automatic t_alu_imm;
    apply(mk(2, 7, {10'h0, 16'hFF80}));
    expect_dec("R9 subi", 23, 32'hFFFFFF80, 1, 1, 0, 0, 0, 0, 0);
    for (int s = 8; s < 12; s++) begin
      apply(mk(2, s, {10'h0, 16'h8000}));
      expect_dec("R9 logic imm", 24 + s - 8, 32'h00008000, 1, 1, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_compares;
    logic [31:0] e;
    for (int c = 0; c < 10; c++) begin
      apply(mk(3, 9, {5'(c), 5'd1, 5'd2, 11'h0}));
      expect_dec("R10 cmp reg", 34 + c, 0, 0, 0, 0, 0, 0, 0, 0);
      apply(mk(2, 14, {5'(c), 5'd1, 16'h8000}));
      e = (c >= 2 && c <= 5) ? 32'h00008000 : 32'hFFFF8000;
      expect_dec("R10 cmp imm", 34 + c, e, 1, 0, 0, 0, 0, 0, 0);
    end
    expect_bad("R10 bad cond 10", mk(3, 9, {5'd10, 21'h0}));
    expect_bad("R10 bad cond 31", mk(2, 14, {5'd31, 21'h0}));
  endtask

  task automatic t_illegal;
    expect_bad("R11 c0s8", mk(0, 8, 26'h3FFFFFF));
    expect_bad("R11 c1s3", mk(1, 3, 26'h0));
    expect_bad("R11 c2s6", mk(2, 6, 26'h0000FFF));
    expect_bad("R11 c2s12", mk(2, 12, 26'h0));
    expect_bad("R11 c2s15", mk(2, 15, 26'h0));
    expect_bad("R11 c3s0", mk(3, 0, 26'h2000000));
    expect_bad("R11 c3s15", mk(3, 15, 26'h0));
  endtask

  task automatic t_enable;
    apply(mk(0, 6, {10'h0, 16'h1234}));
    @(negedge clk);
    insn = mk(3, 15, 26'h0); en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expect_dec("R12 hold", 11, 32'h12340000, 1, 1, 0, 0, 0, 0, 0);
    en = 1'b1;
    @(negedge clk);
    expect_dec("R12 capture", 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fields();
    t_jumps();
    t_sub5();
    t_special();
    t_loads();
    t_stores();
    t_alu_reg();
    t_shifts();
    t_alu_imm();
    t_compares();
    t_illegal();
    t_enable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired got=running exp=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule